// File: doc/BRIEF.md
# Staged Serial Receive Buffer with Hysteretic DTR Throttling

This block sits behind a UART receiver and collects incoming bytes in two stages. Each byte lands first in a 279-entry staging FIFO. A drain engine then moves bytes one at a time into a 64-byte message buffer, which the host reads through a random-access read port. A message is complete when a programmable terminator byte is stored, when a programmable byte count is reached, or when the message buffer fills. At that point the block raises a read-request flag. The host reads the bytes, then acknowledges with a one-cycle pulse. The pulse releases the message buffer for the next message.

While a message waits for the host, later bytes stay in the staging FIFO. The block throttles the remote sender through a DTR output, which follows the free space in the staging FIFO with hysteresis. DTR drops when fewer than 10 entries are free and rises again only once more than 41 entries are free. A synchronous clear empties both stages at once.

The byte input is a valid/ready stream, with one rule for back-pressure. in_ready reports that the staging FIFO has room, but the serial source cannot be held off. A byte offered with in_valid high while in_ready is low is therefore discarded, not stalled, and the loss is recorded in a sticky overrun flag.

Top module: `rx_stage_buffer`

## Requirements
- R1: After reset, dtr is 1, rd_req is 0, msg_len is 0, msg_ovf is 0, overrun is 0 and in_ready is 1.
- R2: The staging FIFO accepts exactly 279 bytes while no drain takes place. in_ready is 0 while it is full. A byte offered while it is full is dropped and sets overrun, which stays at 1 until clr.
- R3: dtr is 0 from one cycle after the staging occupancy reaches 270 or more (fewer than 10 free). At an occupancy of 269, dtr stays 1.
- R4: dtr returns to 1 one cycle after the free space exceeds 41 (occupancy 237 or less). In the band between the two thresholds it keeps its previous level, so with 41 free entries a low dtr stays low.
- R5: Bytes move from staging to the message buffer only while rd_req is 0, at most one per cycle and in arrival order. Byte k of a message is read at rd_addr k on rd_data, combinationally.
- R6: With term_en at 1, a stored byte equal to term_byte ends the message. The terminator is kept as the last byte, and msg_len counts it.
- R7: A nonzero len_limit ends the message when msg_len reaches it. A len_limit of 0 sets no length limit.
- R8: If the 64th byte is stored and neither the terminator nor the length limit matched it, the message ends with msg_ovf at 1. If one of them matched, msg_ovf is 0.
- R9: A one-cycle rd_ack while rd_req is 1 clears rd_req, msg_len and msg_ovf, and draining resumes on the following cycle.
- R10: While rd_req is 1, newly received bytes wait in staging. The pending message's msg_len and content do not change.
- R11: clr empties both stages in the same cycle and clears rd_req, msg_ovf and overrun. It takes priority over a byte offered in that cycle, which is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous flush of both buffers and flags |
| in_valid | input | 1 | Received byte present |
| in_data | input | 8 | Received byte |
| in_ready | output | 1 | Staging FIFO has room |
| overrun | output | 1 | Sticky: a byte was dropped because staging was full |
| dtr | output | 1 | Flow control to the remote sender, 1 = send allowed |
| term_en | input | 1 | Enable terminator framing |
| term_byte | input | 8 | Terminator value |
| len_limit | input | 7 | Fixed message length, 0 = none |
| rd_req | output | 1 | A complete message waits for the host |
| msg_len | output | 7 | Bytes in the message buffer |
| msg_ovf | output | 1 | Message ended because the buffer filled |
| rd_addr | input | 6 | Host read index into the message buffer |
| rd_data | output | 8 | Message byte at rd_addr |
| rd_ack | input | 1 | One-cycle host acknowledge |

## Verification
The assertions take three things about the inputs for granted. The host pulses rd_ack for one cycle and only while rd_req is 1. term_byte, term_en and len_limit hold steady while a message is being assembled. clr is a plain synchronous pulse. The stimulus keeps within these limits. It changes the framing configuration only after every expected message has been acknowledged and staging is empty, and the host model acknowledges each message once, after reading its bytes. The flow-control walk relies on a length limit of 1, so each acknowledge removes exactly one byte from staging.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/rxs_stage_fifo.sv
module rxs_stage_fifo
  import rxs_pkg::*;
#(
  parameter int DEPTH = 279,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  byte_t         push_data,
  input  logic          pop,
  output byte_t         head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  byte_t         mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full && !clr;
  assign do_pop  = pop && !empty && !clr;
  assign head    = mem[rd_ptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      unique case ({do_push, do_pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  // R2: occupancy never passes the depth
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  // R11: flush empties staging on the next cycle
  a_r11_stage_flush: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0));
  // R2: a full FIFO offered a byte with no drain stays full
  a_r2_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop && !clr) |=> full);
endmodule

// File: rtl/rxs_dtr_ctrl.sv
module rxs_dtr_ctrl #(
  parameter int DEPTH     = 279,
  parameter int OFF_BELOW = 10,
  parameter int ON_ABOVE  = 41,
  parameter int CW        = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count,
  output logic          dtr
);
  logic [CW-1:0] free_slots;
  assign free_slots = CW'(DEPTH) - count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            dtr <= 1'b1;
    else if (free_slots < CW'(OFF_BELOW))  dtr <= 1'b0;
    else if (free_slots > CW'(ON_ABOVE))   dtr <= 1'b1;
  end
endmodule

// File: rtl/rxs_drain.sv
module rxs_drain
  import rxs_pkg::*;
#(
  parameter int MSG_DEPTH = 64,
  parameter int MW        = $clog2(MSG_DEPTH + 1),
  parameter int MA        = $clog2(MSG_DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          avail,
  input  byte_t         head,
  input  logic          term_en,
  input  byte_t         term_byte,
  input  logic [MW-1:0] len_limit,
  input  logic          rd_ack,
  input  logic [MA-1:0] rd_addr,
  output logic          pop,
  output logic          rd_req,
  output logic [MW-1:0] msg_len,
  output logic          msg_ovf,
  output byte_t         rd_data
);
  byte_t         mbuf [MSG_DEPTH];
  logic [MW-1:0] wp, next_len;
  logic          hit_term, hit_len, hit_full, ends;

  assign pop      = avail && !rd_req && !clr;
  assign next_len = wp + MW'(1);
  assign hit_term = term_en && (head == term_byte);
  assign hit_len  = (len_limit != '0) && (next_len == len_limit);
  assign hit_full = (next_len == MW'(MSG_DEPTH));
  assign ends     = hit_term || hit_len || hit_full;
  assign msg_len  = wp;
  assign rd_data  = mbuf[rd_addr];

  always_ff @(posedge clk) begin
    if (pop) mbuf[wp[MA-1:0]] <= head;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp      <= '0;
      rd_req  <= 1'b0;
      msg_ovf <= 1'b0;
    end else if (clr || (rd_req && rd_ack)) begin
      wp      <= '0;
      rd_req  <= 1'b0;
      msg_ovf <= 1'b0;
    end else if (pop) begin
      wp <= next_len;
      if (ends) begin
        rd_req  <= 1'b1;
        msg_ovf <= hit_full && !hit_term && !hit_len;
      end
    end
  end

  // R5: nothing is drained while a message waits for the host
  a_r5_hold_while_pending: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> !pop);
  // R10: a pending message keeps its length until acknowledged or cleared
  a_r10_len_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack && !clr) |=> (rd_req && $stable(msg_len)));
  // R9: acknowledge releases the buffer
  a_r9_ack_release: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_ack && !clr) |=> (!rd_req && msg_len == '0 && !msg_ovf));
  // R8: the message never exceeds the buffer
  a_r8_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
    msg_len <= MW'(MSG_DEPTH));
  // R11: flush empties the message buffer
  a_r11_msg_flush: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!rd_req && msg_len == '0 && !msg_ovf));
endmodule

// File: rtl/rx_stage_buffer.sv
module rx_stage_buffer
  import rxs_pkg::*;
#(
  parameter int STAGE_DEPTH = 279,
  parameter int MSG_DEPTH   = 64,
  parameter int DTR_OFF_LT  = 10,
  parameter int DTR_ON_GT   = 41,
  parameter int CW          = $clog2(STAGE_DEPTH + 1),
  parameter int MW          = $clog2(MSG_DEPTH + 1),
  parameter int MA          = $clog2(MSG_DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  output logic          in_ready,
  output logic          overrun,
  output logic          dtr,
  input  logic          term_en,
  input  logic [7:0]    term_byte,
  input  logic [MW-1:0] len_limit,
  output logic          rd_req,
  output logic [MW-1:0] msg_len,
  output logic          msg_ovf,
  input  logic [MA-1:0] rd_addr,
  output logic [7:0]    rd_data,
  input  logic          rd_ack
);
  logic [CW-1:0] stage_count;
  logic          stage_full, stage_empty, drain_pop;
  byte_t         stage_head;

  assign in_ready = !stage_full;

  rxs_stage_fifo #(.DEPTH(STAGE_DEPTH), .CW(CW)) u_stage (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .push(in_valid), .push_data(in_data),
    .pop(drain_pop), .head(stage_head),
    .count(stage_count), .full(stage_full), .empty(stage_empty)
  );

  rxs_dtr_ctrl #(.DEPTH(STAGE_DEPTH), .OFF_BELOW(DTR_OFF_LT),
                 .ON_ABOVE(DTR_ON_GT), .CW(CW)) u_dtr (
    .clk(clk), .rst_n(rst_n), .count(stage_count), .dtr(dtr)
  );

  rxs_drain #(.MSG_DEPTH(MSG_DEPTH), .MW(MW), .MA(MA)) u_drain (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .avail(!stage_empty), .head(stage_head),
    .term_en(term_en), .term_byte(term_byte), .len_limit(len_limit),
    .rd_ack(rd_ack), .rd_addr(rd_addr),
    .pop(drain_pop), .rd_req(rd_req), .msg_len(msg_len),
    .msg_ovf(msg_ovf), .rd_data(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          overrun <= 1'b0;
    else if (clr)                        overrun <= 1'b0;
    else if (in_valid && stage_full)     overrun <= 1'b1;
  end

  // R2: overrun is sticky until clear
  a_r2_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !clr) |=> overrun);
  // R3: too little free space forces dtr low
  a_r3_dtr_off: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_count > CW'(STAGE_DEPTH - DTR_OFF_LT)) |=> !dtr);
  // R4: ample free space forces dtr high
  a_r4_dtr_on: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_count < CW'(STAGE_DEPTH - DTR_ON_GT)) |=> dtr);
  // R4: between the thresholds dtr holds
  a_r4_dtr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((stage_count <= CW'(STAGE_DEPTH - DTR_OFF_LT)) &&
     (stage_count >= CW'(STAGE_DEPTH - DTR_ON_GT))) |=> $stable(dtr));
endmodule

// File: tb/rx_stage_buffer_bench.sv
`timescale 1ns/100ps
module rx_stage_buffer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_ready, overrun, dtr, rd_req, msg_ovf;
  logic       term_en = 1'b0;
  logic [7:0] term_byte = 8'h0A;
  logic [6:0] len_limit = '0;
  logic [6:0] msg_len;
  logic [5:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       mon_ack = 1'b0, man_ack = 1'b0;
  logic       rd_ack;
  assign rd_ack = mon_ack | man_ack;

  int  checks = 0, failures = 0;
  bit  auto_ack = 1'b0;
  int  ack_delay = 2;
  bit  done = 1'b0;
  logic [7:0] exp_bytes[$];
  int         exp_len[$];
  bit         exp_ovf[$];

  always #2.5 clk = ~clk;

  rx_stage_buffer u_rx_stage_buffer (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .overrun(overrun), .dtr(dtr), .term_en(term_en),
    .term_byte(term_byte), .len_limit(len_limit), .rd_req(rd_req),
    .msg_len(msg_len), .msg_ovf(msg_ovf), .rd_addr(rd_addr), .rd_data(rd_data),
    .rd_ack(rd_ack)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    in_valid = 1'b1;
    in_data  = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // driver: queue expectations, then send bytes
  task automatic send_msg(input int n, input bit add_term, input bit ovf);
    exp_len.push_back(n + int'(add_term));
    exp_ovf.push_back(ovf);
    for (int i = 0; i < n; i++) begin
      logic [7:0] b;
      b = 8'h40 + 8'(i % 64);
      exp_bytes.push_back(b);
      send_byte(b);
    end
    if (add_term) begin
      exp_bytes.push_back(term_byte);
      send_byte(term_byte);
    end
  endtask

  task automatic wait_idle();
    for (int t = 0; t < 5000 && exp_len.size() != 0; t++) @(negedge clk);
    repeat (6) @(negedge clk);
    chk(exp_len.size() == 0, "R5 all messages delivered", exp_len.size(), 0);
  endtask

  task automatic man_ack_one();
    man_ack = 1'b1;
    @(negedge clk);
    man_ack = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // monitor: read each completed message and compare with the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (auto_ack && rd_req) begin
        int L;
        repeat (ack_delay) @(negedge clk);
        L = int'(msg_len);
        if (exp_len.size() == 0) begin
          chk(1'b0, "R5 unexpected message", L, 0);
        end else begin
          int el;
          bit eo;
          el = exp_len.pop_front();
          eo = exp_ovf.pop_front();
          chk(L == el, "R6/R7 message length", L, el);
          chk(msg_ovf == eo, "R8 overflow status", int'(msg_ovf), int'(eo));
          for (int i = 0; i < L; i++) begin
            logic [7:0] eb;
            rd_addr = 6'(i);
            #1;
            eb = (exp_bytes.size() != 0) ? exp_bytes.pop_front() : 8'hxx;
            chk(rd_data === eb, "R5 message byte order", int'(rd_data), int'(eb));
          end
        end
        @(negedge clk);
        mon_ack = 1'b1;
        @(negedge clk);
        mon_ack = 1'b0;
        chk(!rd_req && msg_len == 0, "R9 ack releases buffer", int'(rd_req), 0);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dtr == 1'b1, "R1 dtr after reset", int'(dtr), 1);
    chk(rd_req == 1'b0, "R1 rd_req after reset", int'(rd_req), 0);
    chk(msg_len == 0, "R1 msg_len after reset", int'(msg_len), 0);
    chk(overrun == 1'b0 && msg_ovf == 1'b0, "R1 flags after reset", int'(overrun), 0);
    chk(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);

    // R6: terminator framing
    auto_ack = 1'b1;
    term_en = 1'b1; term_byte = 8'h0A; len_limit = 7'd0;
    send_msg(5, 1'b1, 1'b0);
    send_msg(1, 1'b1, 1'b0);
    wait_idle();

    // R7: fixed length framing, two back-to-back messages
    term_en = 1'b0; len_limit = 7'd8;
    send_msg(8, 1'b0, 1'b0);
    send_msg(8, 1'b0, 1'b0);
    wait_idle();

    // R8: buffer fills with no limit -> overflow; exact limit 64 -> no overflow
    len_limit = 7'd0;
    send_msg(64, 1'b0, 1'b1);
    wait_idle();
    len_limit = 7'd64;
    send_msg(64, 1'b0, 1'b0);
    wait_idle();

    // R10: second message waits in staging while first is pending
    auto_ack = 1'b0;
    term_en = 1'b1; len_limit = 7'd0;
    send_msg(3, 1'b1, 1'b0);
    send_msg(2, 1'b1, 1'b0);
    repeat (10) @(negedge clk);
    chk(rd_req == 1'b1, "R10 first message pending", int'(rd_req), 1);
    chk(msg_len == 7'd4, "R10 pending length unchanged", int'(msg_len), 4);
    rd_addr = 6'd3; #1;
    chk(rd_data == 8'h0A, "R6 terminator stored last", int'(rd_data), 10);
    rd_addr = 6'd4; #1;
    chk(msg_len == 7'd4, "R10 second message not drained", int'(msg_len), 4);
    @(negedge clk);
    ack_delay = 20;
    auto_ack = 1'b1;
    wait_idle();
    ack_delay = 2;

    // R11: clear mid-message, with a byte offered in the same cycle
    send_byte(8'h41); send_byte(8'h42); send_byte(8'h43);
    repeat (4) @(negedge clk);
    chk(msg_len == 7'd3, "R5 partial message drained", int'(msg_len), 3);
    clr = 1'b1; in_valid = 1'b1; in_data = 8'h44;
    @(negedge clk);
    clr = 1'b0; in_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(msg_len == 0 && rd_req == 0, "R11 clear empties message buffer", int'(msg_len), 0);
    send_msg(2, 1'b1, 1'b0);
    wait_idle();

    // R3/R4/R2: flow control walk with len_limit 1
    auto_ack = 1'b0;
    term_en = 1'b0; len_limit = 7'd1;
    send_byte(8'h11);
    repeat (3) @(negedge clk);
    chk(rd_req == 1'b1, "R7 length-one message", int'(rd_req), 1);
    for (int i = 0; i < 269; i++) send_byte(8'(i));
    repeat (2) @(negedge clk);
    chk(dtr == 1'b1, "R3 dtr stays high at occupancy 269", int'(dtr), 1);
    send_byte(8'h99);
    repeat (2) @(negedge clk);
    chk(dtr == 1'b0, "R3 dtr low at occupancy 270", int'(dtr), 0);
    for (int i = 0; i < 9; i++) send_byte(8'h55);
    @(negedge clk);
    chk(in_ready == 1'b0, "R2 full at 279", int'(in_ready), 0);
    chk(overrun == 1'b0, "R2 no overrun before drop", int'(overrun), 0);
    send_byte(8'h66);
    @(negedge clk);
    chk(overrun == 1'b1, "R2 overrun set on drop", int'(overrun), 1);
    man_ack_one();
    chk(in_ready == 1'b1, "R2 one slot after one drain", int'(in_ready), 1);
    for (int i = 1; i < 41; i++) man_ack_one();
    chk(dtr == 1'b0, "R4 dtr holds low with 41 free", int'(dtr), 0);
    man_ack_one();
    chk(dtr == 1'b1, "R4 dtr high with 42 free", int'(dtr), 1);
    chk(overrun == 1'b1, "R2 overrun sticky", int'(overrun), 1);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    chk(overrun == 1'b0, "R11 clear resets overrun", int'(overrun), 0);
    chk(rd_req == 1'b0 && msg_len == 0, "R11 clear drops pending message", int'(msg_len), 0);
    repeat (3) @(negedge clk);
    chk(rd_req == 1'b0, "R11 staging empty after clear", int'(rd_req), 0);
    chk(dtr == 1'b1 && in_ready == 1'b1, "R11 dtr and in_ready after clear", int'(dtr), 1);

    summary();
  end
endmodule